// File: doc/BRIEF.md
# Oversampling Serial Receiver with Word Queue

This block receives asynchronous serial characters on a single input line. A 16x baud enable supplies the timing. A falling edge on the idle line starts a frame. Each bit is then decided by a vote of three consecutive samples taken around the middle of the bit. The block assembles a 7-bit or 8-bit word, least significant bit first, optionally followed by a parity bit. It checks the stop bit and places the word, its parity bit and its framing status into a small receive queue.

The host reads the queue through a show-ahead interface. The oldest entry is always visible on the read outputs, a ready flag says the queue holds data, and a one-cycle pop removes the entry. If a word arrives while the queue is full, the whole queue is discarded. With queueing switched off, the block acts as one holding register that each new word overwrites. A separate parity-bit interrupt source follows only the most recently assembled word, whatever the queue holds. This supports multidrop networks that mark address words with the ninth bit.

Top module: `osrx_top`

## Requirements
- R1: A frame starts when `rx` is seen low on a `baud_tick` after being seen high on an earlier tick. The frame is then sampled once per tick, and each received word is pushed once.
- R2: If the vote over the start bit comes out high, no word is produced and the receiver waits for the next falling edge.
- R3: Every bit is decided by the majority of the 7th, 8th and 9th tick samples of that bit. A wrong level lasting a single tick in the middle of a bit does not change the received value.
- R4: With `cfg_len8`=1 the word has 8 data bits; with 0 it has 7 and `rd_data[7]` reads 0. With `cfg_par_en`=1 one more bit follows the data and is stored unchanged in `rd_par`; with 0, `rd_par` reads 0. The format is taken when the start edge is detected.
- R5: A stop bit that votes low sets `rd_ferr`=1 for that entry, and the word is still stored. A high stop bit gives `rd_ferr`=0.
- R6: `ready` is 1 exactly when the queue is not empty. `rd_data`/`rd_par`/`rd_ferr` show the oldest entry, and `pop` removes it in arrival order. A `pop` while the queue is empty has no effect.
- R7: With `cfg_fifo_en`=1 and DEPTH entries held, a new word arriving without a pop in the same cycle empties the queue, and the new word is dropped.
- R8: With `cfg_fifo_en`=0 the block holds at most one word. A new word replaces the held one, and after one pop `ready` is 0.
- R9: `par_irq` equals the parity bit of the most recently assembled word (0 when parity is off). It changes only when a word completes, and pops do not affect it.
- R10: After reset `ready`=0 and `par_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx | input | 1 | Serial line, idle high, synchronous to clk |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_fifo_en | input | 1 | 1: queue of DEPTH words, 0: single holding register |
| pop | input | 1 | Remove the oldest entry |
| ready | output | 1 | Queue not empty |
| rd_data | output | DATA_W | Data of the oldest entry |
| rd_par | output | 1 | Parity bit of the oldest entry |
| rd_ferr | output | 1 | Framing error of the oldest entry |
| par_irq | output | 1 | Parity bit of the last assembled word |

## Verification
The bench builds the block with its defaults: OVS=16, DATA_W=8, DEPTH=8 and voting enabled. It runs the tick at half the clock rate, so start detection has a jitter of one clock and a one-tick glitch covers exactly one of the three votes. With a depth of 8, both the exact-full case and the ninth-word overflow are reached within a few thousand cycles. Random frames mix both word lengths, parity, framing errors and irregular pops to stress queue order against a reference queue.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_BITS,
      RX_STOP
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/osrx_vote.sv
module osrx_vote #(
   parameter int OVS      = 16,
   parameter bit MAJORITY = 1'b1,
   localparam int CW      = $clog2(OVS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rx,
   input  logic [CW-1:0] cnt,
   output logic          bit_val
);
   import osrx_pkg::*;

   localparam logic [CW-1:0] C_FIRST = CW'(OVS / 2 - 2);
   localparam logic [CW-1:0] C_MID   = CW'(OVS / 2 - 1);

   logic s_first;
   logic s_mid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_first <= 1'b1;
         s_mid   <= 1'b1;
      end else if (tick) begin
         if (cnt == C_FIRST) s_first <= rx;
         if (cnt == C_MID)   s_mid   <= rx;
      end
   end

   generate
      if (MAJORITY) begin : g_vote
         assign bit_val = maj3(s_first, s_mid, rx);
      end else begin : g_single
         assign bit_val = s_mid;
      end
   endgenerate

endmodule

// File: rtl/osrx_deframer.sv
module osrx_deframer #(
   parameter int OVS      = 16,
   parameter int DATA_W   = 8,
   parameter bit MAJORITY = 1'b1,
   localparam int CW      = $clog2(OVS),
   localparam int IW      = $clog2(DATA_W),
   localparam int BW      = $clog2(DATA_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              len_full,
   input  logic              par_en,
   output logic              w_valid,
   output logic [DATA_W-1:0] w_data,
   output logic              w_par,
   output logic              w_ferr
);
   import osrx_pkg::*;

   localparam logic [CW-1:0] C_DECIDE = CW'(OVS / 2);
   localparam logic [CW-1:0] C_LAST   = CW'(OVS - 1);
   localparam logic [BW-1:0] N_FULL   = BW'(DATA_W);
   localparam logic [BW-1:0] N_SHORT  = BW'(DATA_W - 1);

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bidx;
   logic              rx_last;
   logic              l_full;
   logic              l_par;
   logic              par_bit;
   logic [DATA_W-1:0] shreg;
   logic              bit_val;
   logic              decide;
   logic [BW-1:0]     n_data;
   logic [BW-1:0]     n_last;

   osrx_vote #(.OVS(OVS), .MAJORITY(MAJORITY)) u_vote (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .rx     (rx),
      .cnt    (cnt),
      .bit_val(bit_val)
   );

   assign decide = tick && (cnt == C_DECIDE);
   assign n_data = l_full ? N_FULL : N_SHORT;
   assign n_last = n_data + BW'(l_par) - BW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         bidx    <= '0;
         rx_last <= 1'b1;
         l_full  <= 1'b1;
         l_par   <= 1'b0;
         par_bit <= 1'b0;
         shreg   <= '0;
         w_valid <= 1'b0;
         w_data  <= '0;
         w_par   <= 1'b0;
         w_ferr  <= 1'b0;
      end else begin
         w_valid <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  rx_last <= rx;
                  if (rx_last && !rx) begin
                     state   <= RX_START;
                     cnt     <= CW'(1);
                     bidx    <= '0;
                     l_full  <= len_full;
                     l_par   <= par_en;
                     par_bit <= 1'b0;
                     shreg   <= '0;
                  end
               end
               RX_START: begin
                  cnt <= cnt + CW'(1);
                  if (decide && bit_val) begin
                     state   <= RX_IDLE;
                     cnt     <= '0;
                     rx_last <= rx;
                  end else if (cnt == C_LAST) begin
                     state <= RX_BITS;
                  end
               end
               RX_BITS: begin
                  cnt <= cnt + CW'(1);
                  if (decide) begin
                     if (bidx < n_data) shreg[bidx[IW-1:0]] <= bit_val;
                     else               par_bit             <= bit_val;
                  end
                  if (cnt == C_LAST) begin
                     if (bidx == n_last) state <= RX_STOP;
                     else                bidx  <= bidx + BW'(1);
                  end
               end
               RX_STOP: begin
                  cnt <= cnt + CW'(1);
                  if (decide) begin
                     w_valid <= 1'b1;
                     w_data  <= shreg;
                     w_par   <= par_bit;
                     w_ferr  <= !bit_val;
                     state   <= RX_IDLE;
                     cnt     <= '0;
                     rx_last <= rx;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/osrx_fifo.sv
module osrx_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 10,
   localparam int AW   = $clog2(DEPTH),
   localparam int NW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [NW-1:0] count,
   output logic          not_empty
);
   localparam logic [NW-1:0] N_FULL = NW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic          do_pop;
   logic          full;
   logic          ovf;
   logic          we;
   logic [AW-1:0] wsel;

   assign not_empty = (count != '0);
   assign full      = (count == N_FULL);
   assign do_pop    = pop && not_empty;
   assign ovf       = en && push && full && !do_pop;
   assign we        = push && !ovf;
   assign wsel      = en ? wr_ptr : rd_ptr;
   assign dout      = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wsel] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (!en) begin
         if (push) begin
            wr_ptr <= rd_ptr + AW'(1);
            count  <= NW'(1);
         end else if (do_pop) begin
            rd_ptr <= rd_ptr + AW'(1);
            count  <= '0;
         end
      end else if (ovf) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push)   wr_ptr <= wr_ptr + AW'(1);
         if (do_pop) rd_ptr <= rd_ptr + AW'(1);
         count <= count + NW'(push) - NW'(do_pop);
      end
   end

endmodule

// File: rtl/osrx_top.sv
module osrx_top #(
   parameter int OVS      = 16,
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 8,
   parameter bit MAJORITY = 1'b1,
   localparam int EW      = DATA_W + 2,
   localparam int NW      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rx,
   input  logic              cfg_len8,
   input  logic              cfg_par_en,
   input  logic              cfg_fifo_en,
   input  logic              pop,
   output logic              ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_par,
   output logic              rd_ferr,
   output logic              par_irq
);

   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("osrx_top: OVS must be a power of two, at least 8");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("osrx_top: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("osrx_top: DATA_W must be at least 2");
      end
   endgenerate

   logic              w_valid;
   logic [DATA_W-1:0] w_data;
   logic              w_par;
   logic              w_ferr;
   logic [EW-1:0]     q_out;
   logic [NW-1:0]     fifo_cnt;

   osrx_deframer #(.OVS(OVS), .DATA_W(DATA_W), .MAJORITY(MAJORITY)) u_deframe (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick),
      .rx      (rx),
      .len_full(cfg_len8),
      .par_en  (cfg_par_en),
      .w_valid (w_valid),
      .w_data  (w_data),
      .w_par   (w_par),
      .w_ferr  (w_ferr)
   );

   osrx_fifo #(.DEPTH(DEPTH), .W(EW)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_fifo_en),
      .push     (w_valid),
      .din      ({w_ferr, w_par, w_data}),
      .pop      (pop),
      .dout     (q_out),
      .count    (fifo_cnt),
      .not_empty(ready)
   );

   assign {rd_ferr, rd_par, rd_data} = q_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       par_irq <= 1'b0;
      else if (w_valid) par_irq <= w_par;
   end

endmodule

// File: rtl/osrx_chk.sv
module osrx_chk #(
   parameter int DEPTH = 8,
   localparam int NW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_fifo_en,
   input logic          pop,
   input logic          ready,
   input logic          par_irq,
   input logic          w_valid,
   input logic [NW-1:0] fifo_cnt
);
   localparam logic [NW-1:0] N_FULL = NW'(DEPTH);

   AST_OVF_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && cfg_fifo_en && fifo_cnt == N_FULL && !pop) |=> !ready); // R7

   AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !w_valid) |=> !ready); // R6

   AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && !(cfg_fifo_en && fifo_cnt == N_FULL && !pop)) |=> ready); // R6

   AST_BYPASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && !cfg_fifo_en) |=> (fifo_cnt == NW'(1))); // R8

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !w_valid |=> $stable(par_irq)); // R9

   AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      w_valid |=> !w_valid); // R1

endmodule

bind osrx_top osrx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_fifo_en(cfg_fifo_en),
   .pop        (pop),
   .ready      (ready),
   .par_irq    (par_irq),
   .w_valid    (w_valid),
   .fifo_cnt   (fifo_cnt)
);

// File: tb/sim_osrx_top.sv
module sim_osrx_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       rx = 1'b1;
   logic       cfg_len8 = 1'b1;
   logic       cfg_par_en = 1'b0;
   logic       cfg_fifo_en = 1'b1;
   logic       pop = 1'b0;
   logic       ready;
   logic [7:0] rd_data;
   logic       rd_par;
   logic       rd_ferr;
   logic       par_irq;

   int checks = 0;
   int errors = 0;
   logic [9:0] exp_q [$];
   logic       exp_irq = 1'b0;
   logic       tdiv = 1'b0;

   always #2 clk = ~clk;

   always @(negedge clk) begin
      tdiv      <= ~tdiv;
      baud_tick <= tdiv;
   end

   osrx_top u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx(rx),
      .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_fifo_en(cfg_fifo_en),
      .pop(pop), .ready(ready), .rd_data(rd_data), .rd_par(rd_par),
      .rd_ferr(rd_ferr), .par_irq(par_irq)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [9:0] entry(input logic [7:0] d, input logic l8, input logic pe,
                                        input logic pb, input logic stop_v);
      return {~stop_v, pe & pb, l8 ? d : {1'b0, d[6:0]}};
   endfunction

   task automatic model_push(input logic [9:0] e, input logic fen);
      exp_irq = e[8];
      if (!fen) begin
         exp_q.delete();
         exp_q.push_back(e);
      end else if (exp_q.size() == 8) begin
         exp_q.delete();
      end else begin
         exp_q.push_back(e);
      end
   endtask

   task automatic line_bit(input logic v, input bit glitch);
      if (glitch) begin
         rx = v;  repeat (15) @(negedge clk);
         rx = ~v; repeat (2)  @(negedge clk);
         rx = v;  repeat (15) @(negedge clk);
      end else begin
         rx = v;  repeat (32) @(negedge clk);
      end
   endtask

   task automatic send(input logic [7:0] d, input logic l8, input logic pe, input logic pb,
                       input logic stop_v, input bit glitch);
      cfg_len8   = l8;
      cfg_par_en = pe;
      line_bit(1'b0, 1'b0);
      for (int i = 0; i < (l8 ? 8 : 7); i++) line_bit(d[i], glitch);
      if (pe) line_bit(pb, glitch);
      line_bit(stop_v, 1'b0);
      rx = 1'b1;
      repeat (8) @(negedge clk);
      model_push(entry(d, l8, pe, pb, stop_v), cfg_fifo_en);
   endtask

   task automatic pop_check(input string req);
      logic [9:0] e;
      chk(ready == 1'b1, req, {31'd0, ready}, 32'd1);
      if (exp_q.size() != 0) begin
         e = exp_q.pop_front();
         chk({rd_ferr, rd_par, rd_data} == e, req, {22'd0, rd_ferr, rd_par, rd_data}, {22'd0, e});
      end
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic l8, pe, pb, sv;
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(ready == 1'b0, "R10 ready", {31'd0, ready}, 0);
      chk(par_irq == 1'b0, "R10 par_irq", {31'd0, par_irq}, 0);

      // R6 pop on empty
      pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
      chk(ready == 1'b0, "R6 pop empty", {31'd0, ready}, 0);

      // R2 false start: 2 clocks low
      rx = 1'b0; repeat (2) @(negedge clk); rx = 1'b1;
      repeat (60) @(negedge clk);
      chk(ready == 1'b0, "R2 false start", {31'd0, ready}, 0);

      // R1 R4 8-bit, no parity
      send(8'hA5, 1, 0, 0, 1, 0);
      pop_check("R1 R4 8bit");
      // R4 7-bit with parity set, R9
      send(8'hFF, 0, 1, 1, 1, 0);
      chk(par_irq == 1'b1, "R9 irq set", {31'd0, par_irq}, 1);
      pop_check("R4 7bit parity");
      chk(par_irq == 1'b1, "R9 irq after pop", {31'd0, par_irq}, 1);
      // R3 glitches mid-bit
      send(8'h3C, 1, 1, 0, 1, 1);
      chk(par_irq == 1'b0, "R9 irq clear", {31'd0, par_irq}, 0);
      pop_check("R3 glitch");
      send(8'hC3, 1, 1, 1, 1, 1);
      pop_check("R3 glitch parity");
      // R5 framing error
      send(8'h5A, 1, 0, 0, 0, 0);
      pop_check("R5 ferr");
      chk(ready == 1'b0, "R6 drained", {31'd0, ready}, 0);

      // R6 exactly full, then in order
      for (int i = 0; i < 8; i++) send(8'(i * 17 + 3), 1, 0, 0, 1, 0);
      chk(ready == 1'b1, "R6 full ready", {31'd0, ready}, 1);
      for (int i = 0; i < 8; i++) pop_check("R6 order");
      chk(ready == 1'b0, "R6 empty after 8", {31'd0, ready}, 0);

      // R7 overflow on ninth word
      for (int i = 0; i < 9; i++) send(8'(i + 8'h40), 1, 0, 0, 1, 0);
      chk(ready == 1'b0, "R7 overflow clears", {31'd0, ready}, 0);
      send(8'h99, 1, 0, 0, 1, 0);
      pop_check("R7 after overflow");

      // R8 bypass
      cfg_fifo_en = 1'b0;
      send(8'h11, 1, 0, 0, 1, 0);
      send(8'h22, 1, 1, 1, 1, 0);
      pop_check("R8 holding reg");
      chk(ready == 1'b0, "R8 one word", {31'd0, ready}, 0);
      cfg_fifo_en = 1'b1;

      // random mix
      for (int n = 0; n < 30; n++) begin
         d  = 8'($urandom);
         l8 = 1'($urandom);
         pe = 1'($urandom);
         pb = 1'($urandom);
         sv = ($urandom % 8) != 0;
         send(d, l8, pe, pb, sv, ($urandom % 4) == 0);
         chk(ready == (exp_q.size() != 0), "R6 random ready", {31'd0, ready}, {31'd0, exp_q.size() != 0});
         chk(par_irq == exp_irq, "R9 random irq", {31'd0, par_irq}, {31'd0, exp_irq});
         for (int k = 0; k < int'($urandom % 3); k++)
            if (exp_q.size() != 0) pop_check("R4 R5 random");
      end
      while (exp_q.size() != 0) pop_check("R6 random drain");
      chk(ready == 1'b0, "R6 final empty", {31'd0, ready}, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule